// File: doc/BRIEF.md
# Program Counter and Branch Address Unit

This block holds the 16-bit program counter of a small 8-bit controller core and works out where the next fetch goes. Each clock it either keeps the counter where it is, moves it forward by the length of the instruction just done, takes a short branch by a signed 8-bit displacement, or loads a full 16-bit jump target. All address arithmetic wraps modulo 2^16.

Alongside the counter it forms, with no clock delay, the address for an indexed read of code memory. That address is a 16-bit base plus the accumulator taken as an unsigned offset. The base is either the data pointer or the current program counter. The block also produces the data pointer plus one, wrapping at the top of the address space, for the core to write back. Fetch, decode and the stack live elsewhere.

Top module: `pc_seq_unit`

## Requirements
- R1: While `rstN` is low the program counter is 0000h, and it leaves reset at 0000h.
- R2: With `branchKind` = 0 (none) and `stepEn` high, the counter advances on the clock edge by `instLen` (0 to 3, where 0 leaves it unchanged), modulo 2^16, so FFFEh plus 3 gives 0001h.
- R3: With `branchKind` = 0 and `stepEn` low, the counter holds its value.
- R4: With `branchKind` = 1 (relative), the counter becomes counter + `instLen` + the sign-extended `relOffset`, modulo 2^16. A 2-byte branch at 2000h with offset 04h lands at 2006h, and offset 80h moves back 128 from the next instruction.
- R5: With `branchKind` = 2 (long), the counter loads `jumpTarget`.
- R6: A branch of kind 1 or 2 wins over `stepEn`, so `stepEn` has no effect in that cycle.
- R7: `branchKind` = 3 is reserved and acts exactly like kind 0.
- R8: With `idxSelPc` low, `codeAddr` equals `ptrIn` + the zero-extended `accIn`, modulo 2^16, in the same cycle. Base 2000h with accumulator 80h gives 2080h.
- R9: With `idxSelPc` high, `codeAddr` equals the current program counter + the zero-extended `accIn`, modulo 2^16.
- R10: `ptrInc` equals `ptrIn` + 1, wrapping FFFFh to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Advance by instruction length |
| instLen | input | 2 | Length in bytes of the finished instruction |
| branchKind | input | 2 | 0 none, 1 relative, 2 long, 3 reserved (as none) |
| relOffset | input | 8 | Signed relative displacement |
| jumpTarget | input | 16 | Absolute target of a long jump |
| accIn | input | 8 | Accumulator, unsigned index |
| ptrIn | input | 16 | Data pointer |
| idxSelPc | input | 1 | Indexed base select: 0 data pointer, 1 program counter |
| pcOut | output | 16 | Program counter |
| codeAddr | output | 16 | Indexed code-read address |
| ptrInc | output | 16 | Data pointer plus one |

## Verification
The bench sweeps every relative displacement from bases near 0000h, in the middle and near FFFFh. This catches a design that zero-extends the offset, which would jump forward on negative displacements, or one that measures from the branch itself, which would land two bytes short. The accumulator is swept over all 256 values against both bases. A sign-extending index would send reads for accumulator values 80h and above into the wrong page. Wrap cases at FFFFh for the counter, the indexed sum and the pointer increment expose carries that spill or saturate. Branches issued with `stepEn` high, and the reserved kind, catch a priority mux that adds the length on top of a long jump or treats kind 3 as a jump.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 2;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_REL  = 2'd1,
    BR_LONG = 2'd2,
    BR_RSVD = 2'd3
  } brKind_t;

  typedef struct packed {
    logic loadTarget;
    logic addOffset;
    logic addLength;
  } pcStrobe_t;
endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic       stepEn,
  input  logic [1:0] branchKind,
  output pcStrobe_t  strb
);
  always_comb begin
    strb = '0;
    unique case (brKind_t'(branchKind))
      BR_REL: begin
        strb.addOffset = 1'b1;
        strb.addLength = 1'b1;
      end
      BR_LONG: strb.loadTarget = 1'b1;
      default: strb.addLength = stepEn;
    endcase
  end
endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  pcStrobe_t     strb,
  input  logic [LW-1:0] instLen,
  input  logic [DW-1:0] relOffset,
  input  logic [AW-1:0] jumpTarget,
  input  logic [DW-1:0] accIn,
  input  logic [AW-1:0] ptrIn,
  input  logic          idxSelPc,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] codeAddr,
  output logic [AW-1:0] ptrInc
);
  localparam int OFF_PAD = AW - DW;
  localparam int LEN_PAD = AW - LW;

  logic [AW-1:0] pcQ;
  logic [AW-1:0] lenExt;
  logic [AW-1:0] offExt;
  logic [AW-1:0] accExt;
  logic [AW-1:0] seqAddr;
  logic [AW-1:0] relAddr;
  logic [AW-1:0] nextPc;
  logic [AW-1:0] idxBase;
  logic          pcWe;

  assign lenExt  = {{LEN_PAD{1'b0}}, instLen};
  assign offExt  = {{OFF_PAD{relOffset[DW-1]}}, relOffset};
  assign accExt  = {{OFF_PAD{1'b0}}, accIn};
  assign seqAddr = pcQ + lenExt;
  assign relAddr = seqAddr + offExt;
  assign pcWe    = strb.loadTarget | strb.addLength;

  always_comb begin
    if (strb.loadTarget)     nextPc = jumpTarget;
    else if (strb.addOffset) nextPc = relAddr;
    else                     nextPc = seqAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     pcQ <= '0;
    else if (pcWe) pcQ <= nextPc;
  end

  assign idxBase  = idxSelPc ? pcQ : ptrIn;
  assign codeAddr = idxBase + accExt;
  assign ptrInc   = ptrIn + {{(AW-1){1'b0}}, 1'b1};
  assign pcOut    = pcQ;
endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [LEN_W-1:0]  instLen,
  input  logic [1:0]        branchKind,
  input  logic [DATA_W-1:0] relOffset,
  input  logic [ADDR_W-1:0] jumpTarget,
  input  logic [DATA_W-1:0] accIn,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic              idxSelPc,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] codeAddr,
  output logic [ADDR_W-1:0] ptrInc
);
  pcStrobe_t strb;

  pc_seq_ctrl u_ctrl (
    .stepEn    (stepEn),
    .branchKind(branchKind),
    .strb      (strb)
  );

  pc_seq_dp #(.AW(ADDR_W), .DW(DATA_W), .LW(LEN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .instLen   (instLen),
    .relOffset (relOffset),
    .jumpTarget(jumpTarget),
    .accIn     (accIn),
    .ptrIn     (ptrIn),
    .idxSelPc  (idxSelPc),
    .pcOut     (pcOut),
    .codeAddr  (codeAddr),
    .ptrInc    (ptrInc)
  );
endmodule

// File: rtl/pc_seq_chk.sv
module pc_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stepEn,
  input logic [1:0]  instLen,
  input logic [1:0]  branchKind,
  input logic [7:0]  relOffset,
  input logic [15:0] jumpTarget,
  input logic [7:0]  accIn,
  input logic [15:0] ptrIn,
  input logic        idxSelPc,
  input logic [15:0] pcOut,
  input logic [15:0] codeAddr,
  input logic [15:0] ptrInc
);
  logic plainKind;
  assign plainKind = (branchKind == 2'd0) || (branchKind == 2'd3);

  // R1
  always @(negedge clk) if (!rstN) reset_pc_zero_chk: assert (pcOut == 16'h0000);

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (plainKind && stepEn) |=> pcOut == 16'($past(pcOut) + {14'd0, $past(instLen)}));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (plainKind && !stepEn) |=> $stable(pcOut));

  // R4
  rel_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchKind == 2'd1) |=> pcOut == 16'($past(pcOut) + {14'd0, $past(instLen)}
                                          + {{8{$past(relOffset[7])}}, $past(relOffset)}));

  // R5 R6
  long_jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchKind == 2'd2) |=> pcOut == $past(jumpTarget));

  // R8 R9
  always @(negedge clk) if (rstN)
    idx_addr_chk: assert (codeAddr == 16'((idxSelPc ? pcOut : ptrIn) + {8'd0, accIn}));

  // R10
  always @(negedge clk) if (rstN)
    ptr_inc_chk: assert (ptrInc == 16'(ptrIn + 16'd1));
endmodule

bind pc_seq_unit pc_seq_chk u_chk (.*);

// File: tb/pc_seq_unit_tb.sv
`timescale 1ns/1ps
module pc_seq_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        stepEn;
  logic [1:0]  instLen;
  logic [1:0]  branchKind;
  logic [7:0]  relOffset;
  logic [15:0] jumpTarget;
  logic [7:0]  accIn;
  logic [15:0] ptrIn;
  logic        idxSelPc;
  logic [15:0] pcOut;
  logic [15:0] codeAddr;
  logic [15:0] ptrInc;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] expPc;

  always #4 clk = ~clk;

  pc_seq_unit u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, check at following negedge
  task automatic cyc(input logic st, input logic [1:0] k, input logic [1:0] len,
                     input logic [7:0] off, input logic [15:0] tgt, input string req);
    stepEn = st; branchKind = k; instLen = len; relOffset = off; jumpTarget = tgt;
    if (k == 2'd2)      expPc = tgt;
    else if (k == 2'd1) expPc = 16'(expPc + {14'd0, len} + {{8{off[7]}}, off});
    else if (st)        expPc = 16'(expPc + {14'd0, len});
    @(negedge clk);
    chk(req, pcOut, expPc);
  endtask

  task automatic jumpTo(input logic [15:0] a);
    cyc(1'b0, 2'd2, 2'd0, 8'd0, a, "R5");
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; stepEn = 1'b1; instLen = 2'd3; branchKind = 2'd2;
    relOffset = 8'h7F; jumpTarget = 16'hBEEF; accIn = 8'd0; ptrIn = 16'd0; idxSelPc = 1'b0;
    expPc = 16'h0000;
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", pcOut, 16'h0000);
    branchKind = 2'd0; stepEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", pcOut, 16'h0000);

    // R3 hold, R7 reserved kind without step also holds
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd0, 2'(i), 8'hFF, 16'h1234, "R3");
    for (int i = 0; i < 4; i++) cyc(1'b0, 2'd3, 2'(i), 8'h10, 16'h5555, "R7 hold");

    // R2 sequential advance for every length
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 4; r++) cyc(1'b1, 2'd0, 2'(l), 8'h00, 16'h0, "R2");
    jumpTo(16'hFFFE);
    cyc(1'b1, 2'd0, 2'd3, 8'h00, 16'h0, "R2 wrap");
    chk("R2 wrap value", pcOut, 16'h0001);

    // R7 reserved kind with step acts as plain step
    cyc(1'b1, 2'd3, 2'd2, 8'h80, 16'hAAAA, "R7 step");

    // R5 long jumps over a spread of targets
    for (int i = 0; i < 64; i++) jumpTo(16'(i * 16'h0409) ^ 16'hA5C3);
    jumpTo(16'hFFFF);
    jumpTo(16'h0000);

    // R4 example
    jumpTo(16'h2000);
    cyc(1'b0, 2'd1, 2'd2, 8'h04, 16'h0, "R4 example");
    chk("R4 example value", pcOut, 16'h2006);

    // R4 sweep of all offsets from three bases, R6 with step alternating
    for (int b = 0; b < 3; b++)
      for (int o = 0; o < 256; o++) begin
        jumpTo(b == 0 ? 16'h2000 : (b == 1 ? 16'hFFF0 : 16'h0005));
        cyc(o[0], 2'd1, 2'((o % 3) + 1), 8'(o), 16'h0, o[0] ? "R6 rel" : "R4");
      end

    // R6 long jump with step asserted
    jumpTo(16'h1000);
    cyc(1'b1, 2'd2, 2'd3, 8'h00, 16'h7777, "R6 long");
    chk("R6 long value", pcOut, 16'h7777);

    // R8 indexed from data pointer
    idxSelPc = 1'b0;
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 256; a++) begin
        ptrIn = (p == 0) ? 16'h2000 : ((p == 1) ? 16'hFFC0 : 16'h0000);
        accIn = 8'(a);
        #1;
        chk("R8", codeAddr, 16'(ptrIn + a));
      end
    ptrIn = 16'h2000; accIn = 8'h80; #1;
    chk("R8 example", codeAddr, 16'h2080);

    // R9 indexed from program counter
    jumpTo(16'hFFA0);
    idxSelPc = 1'b1; ptrIn = 16'h1111;
    for (int a = 0; a < 256; a++) begin
      accIn = 8'(a);
      #1;
      chk("R9", codeAddr, 16'(16'hFFA0 + a));
    end
    idxSelPc = 1'b0;

    // R10 pointer increment
    for (int v = 0; v < 1024; v++) begin
      ptrIn = 16'(v * 61 + 16'hFC00);
      #1;
      chk("R10", ptrInc, 16'(ptrIn + 1));
    end
    ptrIn = 16'hFFFF; #1;
    chk("R10 wrap", ptrInc, 16'h0000);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule